// File: doc/BRIEF.md
# Single-Input-Change Pair Pattern Generator

This block is a built-in self-test stimulus source for a combinational circuit under test with `WIDTH` inputs. It emits one `WIDTH`-bit pattern per enabled clock. The run is split into `WIDTH` phases of 2^`WIDTH` patterns each, so one full run lasts `WIDTH` × 2^`WIDTH` enabled cycles. Any two consecutive patterns differ in exactly one bit, including across phase boundaries and the wrap from the end of the run back to its start. Over one run, every ordered pair (v, v with one bit flipped) appears exactly once. That is the smallest number of cycles that can hold all such pairs, which makes the block useful for stuck-open and transition-delay testing.

Internally a binary counter is turned into a reflected Gray word. A phase counter sets how far that word is rotated right. A small decoder with an OR of the phase bits then builds an inversion mask that flips selected bits of the rotated word. The `go` input stalls the whole sequence. `last_pat` marks the final pattern of the run, so a response compactor can close its signature there.

Top module: `sic_pair_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to phase 0 and count 0. After that edge, `pat` is all zeros and `last_pat` is 0.
- R2: In phase 0, after c enabled steps, `pat` equals the reflected Gray code of c, defined as c XOR (c >> 1) (for 3 bits: 000,001,011,010,110,111,101,100).
- R3: In phase p (1 ≤ p < `WIDTH`), `pat` is the Gray word of the count rotated right by p bit positions, XORed with a mask. The mask has exactly two set bits: bit 0 and bit `WIDTH`-p.
- R4: The phase advances after 2^`WIDTH` enabled steps. After phase `WIDTH`-1 it returns to phase 0, also when `WIDTH` is not a power of two. The whole sequence therefore repeats every `WIDTH` × 2^`WIDTH` enabled steps and restarts at all zeros.
- R5: Every enabled step changes exactly one bit of `pat`. This includes steps across a phase boundary and the wrap back to the start.
- R6: Over one full run from reset, every ordered pair (v, v XOR 2^b), with b from 0 to `WIDTH`-1, appears exactly once as two consecutive patterns.
- R7: `last_pat` is 1 exactly while `pat` shows the final pattern of phase `WIDTH`-1, and is 0 at all other times.
- R8: While `go` is low, `pat` and `last_pat` hold their values, and the sequence resumes from the same place once `go` rises again.
- R9: A reset applied in the middle of a run restarts the sequence at phase 0 with `pat` all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Advance one pattern per clock while high; stall while low |
| pat | output | WIDTH | Current test pattern for the circuit under test |
| last_pat | output | 1 | High while the last pattern of the final phase is shown |

## Verification
The bench targets the seams of the sequence: the step from the last pattern of one phase into the next, and the wrap from phase `WIDTH`-1 back to phase 0 at widths 3, 4, 5 and 6.

- At the non-power-of-two widths, a phase counter that runs past `WIDTH`-1 would emit extra phases. Those phases would repeat pairs, and the per-pair tally over one run would expose them.
- A mask bit placed at the wrong position would make a boundary step flip two bits, or would leave some ordered pair unvisited.
- Random stalls on `go`, including a stall held on the final pattern, show whether a design advances or drops `last_pat` while stalled.
- A reset in the middle of a run shows whether the design fails to restart at all zeros.

// File: rtl/sic_pair_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the single-input-change pair generator.
// Assumes pattern widths of 2 or more.
package sic_pair_pkg;
    // Number of bits needed to count phases 0 .. n-1 (at least one bit).
    function automatic int phase_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sic_step_counter.sv
`timescale 1ns/1ps
// Module: sic_step_counter
// Holds the in-phase binary count and the phase index. The count wraps
// every 2^WIDTH enabled steps. At each count wrap the phase advances,
// and it returns to 0 after WIDTH-1 (not after 2^PW-1).
// Assumes WIDTH >= 2 and PW large enough to hold WIDTH-1.
module sic_step_counter #(
    parameter int WIDTH = 4,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic [WIDTH-1:0] count,
    output logic [PW-1:0]    phase,
    output logic             run_end
);
    localparam logic [WIDTH-1:0] CNT_TOP    = '1;
    localparam logic [PW-1:0]    PHASE_LAST = PW'(WIDTH - 1);

    logic count_top;
    assign count_top = (count == CNT_TOP);

    // Advance the count each enabled cycle, and bump or wrap the phase at count wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            phase <= '0;
        end else if (go) begin
            count <= count + 1'b1;
            if (count_top) begin
                phase <= (phase == PHASE_LAST) ? '0 : phase + 1'b1;
            end
        end
    end

    // Flag the final step of the final phase.
    assign run_end = count_top && (phase == PHASE_LAST);

    // R4: the phase index never leaves the range 0 .. WIDTH-1.
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PHASE_LAST);

    // R4: an enabled step at the end of the run restarts phase 0, count 0.
    p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && run_end) |=> (phase == '0 && count == '0));
endmodule

// File: rtl/sic_gray_rotator.sv
`timescale 1ns/1ps
// Module: sic_gray_rotator
// Turns the binary count into reflected Gray code, then rotates it right
// by the phase index through a logarithmic barrel shifter. Stage s
// rotates by 2^s when phase bit s is set.
// Assumes phase < WIDTH, so each stage amount stays below WIDTH.
module sic_gray_rotator #(
    parameter int WIDTH = 4,
    parameter int PW    = 2
) (
    input  logic [WIDTH-1:0] count,
    input  logic [PW-1:0]    phase,
    output logic [WIDTH-1:0] rotated
);
    logic [WIDTH-1:0] stage [PW+1];

    // Gray word: each bit XORs a count bit with its upper neighbour.
    assign stage[0] = count ^ (count >> 1);

    for (genvar s = 0; s < PW; s++) begin : g_rot_stage
        localparam int AMT = (1 << s) % WIDTH;
        logic [WIDTH-1:0] turned;
        // Fixed right rotation by AMT for this stage.
        assign turned = (stage[s] >> AMT) | (stage[s] << (WIDTH - AMT));
        // Select rotated or passed-through word by this phase bit.
        assign stage[s+1] = phase[s] ? turned : stage[s];
    end

    assign rotated = stage[PW];
endmodule

// File: rtl/sic_phase_mask.sv
`timescale 1ns/1ps
// Module: sic_phase_mask
// Builds the inversion mask for the current phase. An OR of the phase
// bits gives "not phase 0". It sets mask bit 0 and enables a decoder
// that sets mask bit WIDTH-p. Only WIDTH-1 decoder outputs exist.
// Assumes phase < WIDTH.
module sic_phase_mask #(
    parameter int WIDTH = 4,
    parameter int PW    = 2
) (
    input  logic [PW-1:0]    phase,
    output logic [WIDTH-1:0] mask
);
    logic             nonzero;
    logic [WIDTH-1:0] pick;

    // Enable: high in every phase except phase 0.
    assign nonzero = |phase;

    for (genvar j = 0; j < WIDTH; j++) begin : g_dec
        if (j == 0) begin : g_unused
            // Position 0 would need phase WIDTH, which never occurs.
            assign pick[j] = 1'b0;
        end else begin : g_sel
            localparam logic [PW-1:0] CODE = PW'(WIDTH - j);
            // Decoder output j fires in phase WIDTH-j.
            assign pick[j] = nonzero && (phase == CODE);
        end
    end

    assign mask = pick | {{(WIDTH-1){1'b0}}, nonzero};
endmodule

// File: rtl/sic_pair_gen.sv
`timescale 1ns/1ps
// Module: sic_pair_gen (top)
// Single-input-change pair pattern source. Each enabled cycle it shows
// the next pattern of a WIDTH x 2^WIDTH sequence in which neighbours
// differ in one bit and every ordered one-bit pair occurs once.
// Assumes WIDTH >= 2. The output is combinational from the counter state.
module sic_pair_gen
    import sic_pair_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic [WIDTH-1:0] pat,
    output logic             last_pat
);
    localparam int PW = phase_width(WIDTH);

    logic [WIDTH-1:0] count;
    logic [PW-1:0]    phase;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] mask;
    logic             run_end;

    sic_step_counter #(.WIDTH(WIDTH), .PW(PW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .count   (count),
        .phase   (phase),
        .run_end (run_end)
    );

    sic_gray_rotator #(.WIDTH(WIDTH), .PW(PW)) u_rot (
        .count   (count),
        .phase   (phase),
        .rotated (rotated)
    );

    sic_phase_mask #(.WIDTH(WIDTH), .PW(PW)) u_mask (
        .phase (phase),
        .mask  (mask)
    );

    // Final pattern: rotated Gray word with the phase inversions applied.
    assign pat      = rotated ^ mask;
    assign last_pat = run_end;

    // R3: outside phase 0 the mask holds bit 0 and exactly one other bit.
    p_mask_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> ($countones(mask) == 2 && mask[0]));

    // R5: every enabled step flips exactly one output bit.
    p_one_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> ($countones(pat ^ $past(pat)) == 1));

    // R8: a stalled cycle leaves the pattern and the end flag unchanged.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(pat) && $stable(last_pat)));

    // R4: stepping past the final pattern restarts at all zeros.
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && last_pat) |=> (pat == '0 && !last_pat));
endmodule

// File: tb/sic_pair_gen_test.sv
`timescale 1ns/1ps
// Bench: four generators (widths 3, 4, 5, 6) share clock, reset and go.
// Each is compared every cycle against a model computed from the
// requirements, and its one-bit pairs are tallied over one full run.
module sic_pair_gen_test;
    localparam int ND     = 4;
    localparam int NW[ND] = '{3, 4, 5, 6};

    logic clk = 1'b0;
    logic rst_n;
    logic go;
    logic [2:0] p3;
    logic [3:0] p4;
    logic [4:0] p5;
    logic [5:0] p6;
    logic d3, d4, d5, d6;

    always #5 clk = ~clk;

    sic_pair_gen #(.WIDTH(5)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .pat(p5), .last_pat(d5));
    sic_pair_gen #(.WIDTH(3)) uut_w3 (
        .clk(clk), .rst_n(rst_n), .go(go), .pat(p3), .last_pat(d3));
    sic_pair_gen #(.WIDTH(4)) uut_w4 (
        .clk(clk), .rst_n(rst_n), .go(go), .pat(p4), .last_pat(d4));
    sic_pair_gen #(.WIDTH(6)) uut_w6 (
        .clk(clk), .rst_n(rst_n), .go(go), .pat(p6), .last_pat(d6));

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int pos   [ND];
    int prev  [ND];
    int steps [ND];
    int seen  [ND][384];

    function automatic int pat_of(input int d);
        case (d)
            0:       return int'(p3);
            1:       return int'(p4);
            2:       return int'(p5);
            default: return int'(p6);
        endcase
    endfunction

    function automatic bit end_of(input int d);
        case (d)
            0:       return d3;
            1:       return d4;
            2:       return d5;
            default: return d6;
        endcase
    endfunction

    function automatic int rotr(input int v, input int r, input int n);
        return ((v >> r) | (v << (n - r))) & ((1 << n) - 1);
    endfunction

    // Expected pattern at run position ps for width n (R2, R3).
    function automatic int exp_pat(input int n, input int ps);
        int ph = ps >> n;
        int c  = ps & ((1 << n) - 1);
        int g  = c ^ (c >> 1);
        int m  = (ph == 0) ? 0 : ((1 << (n - ph)) | 1);
        return rotr(g, ph, n) ^ m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One clock with the given go/reset, then compare every generator.
    task automatic tick(input bit e, input bit r);
        go    = e;
        rst_n = r;
        @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            int n   = NW[d];
            int per = n << n;
            int cur = pat_of(d);
            int ex;
            if (!r) begin
                pos[d]   = 0;
                steps[d] = 0;
            end else if (e) begin
                int diff = cur ^ prev[d];
                check($countones(diff) == 1, "R5", "one-bit step", diff, 1);
                if (steps[d] < per && $countones(diff) == 1) begin
                    for (int b = 0; b < n; b++)
                        if (diff == (1 << b)) seen[d][b*64 + prev[d]]++;
                end
                steps[d]++;
                pos[d] = (pos[d] + 1) % per;
                if (pos[d] == 0)
                    check(cur == 0, "R4", "wrap to all zeros", cur, 0);
            end else begin
                check(cur == prev[d], "R8", "stall hold", cur, prev[d]);
            end
            ex = exp_pat(n, pos[d]);
            check(cur == ex, ((pos[d] >> n) == 0) ? "R2" : "R3", "pattern", cur, ex);
            check(end_of(d) == (pos[d] == per - 1), "R7", "last_pat",
                  int'(end_of(d)), int'(pos[d] == per - 1));
            prev[d] = cur;
        end
    endtask

    initial begin
        int bad;
        void'($urandom(32'h5EED_0042));
        for (int d = 0; d < ND; d++) begin
            pos[d] = 0; prev[d] = 0; steps[d] = 0;
            for (int k = 0; k < 384; k++) seen[d][k] = 0;
        end
        go = 1'b0;
        rst_n = 1'b0;
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        // R1: reset state at the ports.
        for (int d = 0; d < ND; d++) begin
            check(pat_of(d) == 0, "R1", "reset pattern", pat_of(d), 0);
            check(end_of(d) == 1'b0, "R1", "reset last_pat", int'(end_of(d)), 0);
        end
        // Full run of the widest generator with random stalls (R2-R8).
        while (steps[3] < (6 << 6)) tick($urandom_range(0, 3) != 0, 1'b1);
        // R6: every ordered one-bit pair seen exactly once per width.
        for (int d = 0; d < ND; d++) begin
            bad = 0;
            for (int b = 0; b < NW[d]; b++)
                for (int v = 0; v < (1 << NW[d]); v++)
                    if (seen[d][b*64 + v] != 1) bad++;
            check(bad == 0, "R6", "pairs not seen exactly once", bad, 0);
        end
        // R7/R8: hold on the final pattern of the width-3 run, then wrap.
        while (!d3) tick(1'b1, 1'b1);
        repeat (4) tick(1'b0, 1'b1);
        check(d3 == 1'b1, "R8", "last_pat held in stall", int'(d3), 1);
        tick(1'b1, 1'b1);
        check(p3 == 3'd0, "R4", "width-3 wrap", int'(p3), 0);
        // R9: reset in the middle of a run.
        repeat (37) tick(1'b1, 1'b1);
        tick(1'b1, 1'b0);
        for (int d = 0; d < ND; d++)
            check(pat_of(d) == 0, "R9", "mid-run reset", pat_of(d), 0);
        repeat (20) tick($urandom_range(0, 1) != 0, 1'b1);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule